// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned W-bit operands over W clock cycles. It uses one W-bit adder and one double-width accumulator. A one-cycle `start` pulse, given while the unit is idle, captures both operands. The first operand is held in a multiplicand register. The second is placed in the lower half of the accumulator, and the upper half is cleared.

On each iteration the accumulator's least significant bit selects one of two values for the upper half: the upper half plus the multiplicand, or the upper half unchanged. The whole accumulator then shifts right by one place in the same cycle. The adder's carry enters at the top bit, and the consumed multiplier bit leaves at the bottom.

The controller has three states. IDLE moves to RUN when `start` is high (transition *accept*). RUN stays in RUN for W iterations (transition *iterate*) and moves to DONE after the last one (transition *finish*). DONE always returns to IDLE after one cycle (transition *release*). The product stays on `product` until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: When `done` is 1, `product` equals the full 2W-bit unsigned product of the `mcand_in` and `mplier_in` values sampled at the accepting edge.
- R3: `done` becomes 1 on the W-th rising edge after the edge that samples `start` in IDLE.
- R4: `done` is high for exactly one cycle. In the following cycle `busy` is 0 and the unit accepts a new start.
- R5: `busy` is 1 from the edge after the accepting edge through the last iteration, and is 0 while `done` is 1.
- R6: A `start` pulse or an operand change while `busy` is 1 has no effect on the result or on the latency.
- R7: While idle and with no start, `product` keeps its last value whatever the operand inputs do.
- R8: No adder carry is lost: an all-ones by all-ones multiply yields (2^W-1)^2.
- R9: In a W=4 instance, multiplicand 1000 times multiplier 1001 yields 01001000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; honoured only in IDLE |
| mcand_in | input | W | Multiplicand operand |
| mplier_in | input | W | Multiplier operand |
| busy | output | 1 | High while iterating |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2W | Accumulator contents, the result after `done` |

## Verification
A wrong iteration count or a stuck controller state shows up directly at the ports. In that case `done` arrives on the wrong cycle, never arrives, or arrives with `busy` still high, and this can be seen within W+1 cycles of the start. A lost carry or a misaligned shift in the accumulator gives the wrong `product` in the same cycle that `done` rises. The bench stresses this with all-ones operands and single set bits, and it sweeps the 4-bit instance exhaustively.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_e state, state_nx;
    logic [CW-1:0] iter;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (iter == LAST) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    iter <= '0;
        else if (load) iter <= '0;
        else if (step) iter <= iter + 1'b1;
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_RUN:  begin step = 1'b1; busy = 1'b1; end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R3
    iter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(iter) == LAST);

    // R6
    iter_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iter != LAST) |=> busy && iter == $past(iter) + 1'b1);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] acc_q;
    logic [W:0]    upper_sum;

    always_comb begin
        if (acc_q[0]) upper_sum = {1'b0, acc_q[PW-1:W]} + {1'b0, mcand_q};
        else          upper_sum = {1'b0, acc_q[PW-1:W]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc_q   <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            acc_q   <= {upper_sum, acc_q[W-1:1]};
        end
    end

    assign product = acc_q;

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(product));

    // R6
    mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    logic load, step;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .product   (product)
    );

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        st32 = 1'b0, st4 = 1'b0;
    logic [31:0] a32 = '0, b32 = '0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic        busy32, done32, busy4, done4;
    logic [63:0] p32;
    logic [7:0]  p4;

    shift_add_mul #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(st32), .mcand_in(a32), .mplier_in(b32),
        .busy(busy32), .done(done32), .product(p32)
    );

    shift_add_mul #(.W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .start(st4), .mcand_in(a4), .mplier_in(b4),
        .busy(busy4), .done(done4), .product(p4)
    );

    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref32(input logic [31:0] x, input logic [31:0] y);
        return {32'b0, x} * {32'b0, y};
    endfunction

    function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
        return {4'b0, x} * {4'b0, y};
    endfunction

    task automatic mul32(input logic [31:0] x, input logic [31:0] y, input bit meddle, input string req);
        int cyc;
        @(negedge clk);
        a32 = x; b32 = y; st32 = 1'b1;
        @(negedge clk);
        st32 = 1'b0;
        cyc = 1;
        chk(busy32 == 1'b1, "R5", {63'b0, busy32}, 64'd1);
        while (!done32 && cyc < 200) begin
            if (meddle && cyc == 5) begin
                st32 = 1'b1; a32 = ~x; b32 = y + 32'd7;
            end
            @(negedge clk);
            st32 = 1'b0;
            cyc++;
        end
        chk(cyc == 33, "R3", 64'(cyc), 64'd33);
        chk(busy32 == 1'b0, "R5", {63'b0, busy32}, 64'd0);
        chk(p32 == ref32(x, y), req, p32, ref32(x, y));
        @(negedge clk);
        chk(done32 == 1'b0 && busy32 == 1'b0, "R4", {62'b0, done32, busy32}, 64'd0);
    endtask

    task automatic mul4(input logic [3:0] x, input logic [3:0] y, input string req);
        int cyc;
        @(negedge clk);
        a4 = x; b4 = y; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        cyc = 1;
        while (!done4 && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 5, "R3", 64'(cyc), 64'd5);
        chk(p4 == ref4(x, y), req, {56'b0, p4}, {56'b0, ref4(x, y)});
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy32 == 0 && done32 == 0 && p32 == 0, "R1", p32, 64'd0);
        chk(busy4 == 0 && done4 == 0 && p4 == 0, "R1", {56'b0, p4}, 64'd0);
        rst_n = 1'b1;

        // R9 worked 4-bit example
        mul4(4'b1000, 4'b1001, "R9");
        chk(p4 == 8'b0100_1000, "R9", {56'b0, p4}, 64'h48);
        // R2 exhaustive 4-bit
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                mul4(4'(i), 4'(j), "R2");

        // R8 carry preservation, R2 corners
        mul32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8");
        mul32(32'h0, 32'hFFFF_FFFF, 1'b0, "R2");
        mul32(32'hFFFF_FFFF, 32'h0, 1'b0, "R2");
        mul32(32'h8000_0000, 32'h8000_0000, 1'b0, "R8");
        mul32(32'h0000_0001, 32'hDEAD_BEEF, 1'b0, "R2");
        mul32(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R8");

        // R6 start and operand changes mid-run ignored
        mul32(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R6");
        mul32(32'hFFFF_0000, 32'h0F0F_0F0F, 1'b1, "R6");

        // R7 product held while idle
        held = p32;
        for (int k = 0; k < 4; k++) begin
            a32 = $urandom; b32 = $urandom;
            @(negedge clk);
            chk(p32 == held && busy32 == 0, "R7", p32, held);
        end

        // R2 random
        for (int k = 0; k < 40; k++) begin
            logic [31:0] x, y;
            x = $urandom; y = $urandom;
            if (k % 8 == 0) x = 32'h1 << (k % 32);
            mul32(x, y, 1'b0, "R2");
        end

        summary();
        $finish;
    end
endmodule